// File: doc/BRIEF.md
# Bus Address Decoder with Resizable Windows and Write Guard

This block sits on the address path of a 32-bit processor bus. For each access it gives one result: boot ROM, RAM, the peripheral register window, or invalid. An invalid access raises a memory-exception trap. The ROM window starts at address zero and the RAM window starts at `0x0200_0000`. The length of each window comes from a small size code held in a configuration word, so software can enlarge the windows after boot. After reset both windows are at their smallest.

The peripheral window is 256 bytes at `0x01F8_0000` and is held as a bank of 32-bit words. Every word in the bank can be written and read back, and an access to the window never traps. A few words have a meaning for the decoder: the control word, the configuration word and two segment-bound words. All other words are scratch storage. When the guard bit in the control word is set, a write to RAM outside the programmed word range is trapped. Reads are never blocked by the guard.

Each access is presented for one cycle. Its result appears on the response outputs on the following clock edge.

Top module: `addr_guard`

## Requirements
- R1: While reset is held and in the first cycle after it, `rsp_valid`, `rsp_trap` and `rsp_rdata` are 0. All window words reset to 0, so the decoder starts with 4 KB of ROM, 256 KB of RAM and the guard off.
- R2: An access with `acc_valid` high gives `rsp_valid` high on the next clock edge. A cycle without an access gives `rsp_valid` low. `rsp_region` encodes 0 = ROM, 1 = RAM, 2 = peripheral window, 3 = invalid.
- R3: An address below 4 KB shifted left by the ROM size code (bits 20:18 of the window word at byte offset 0x10) is ROM. A code of 7 gives 512 KB. At or above that limit, and outside the other windows, the address is invalid.
- R4: An address from `0x0200_0000` up to, but not including, that base plus 256 KB shifted left by the RAM size code (bits 12:10 of the word at offset 0x10) is RAM. Any code of 4 or more gives 4 MB.
- R5: An address in none of the windows returns region 3 with `rsp_trap` high, for reads and for writes.
- R6: An access inside `0x01F8_0000`–`0x01F8_00FF` returns region 2 and never traps. The word index is address bits 7:2. A write stores `acc_wdata` at that index. `rsp_rdata` returns the word's value before the access. Outside the window `rsp_rdata` is 0.
- R7: Bits of the configuration word other than the two size codes have no effect on decoding.
- R8: When bit 3 of the word at offset 0x00 is set, a RAM write is trapped if its word offset, (address − `0x0200_0000`) >> 2, is below bits 19:0 of the word at offset 0x20 or above bits 19:0 of the word at offset 0x24. The response reports region 1 with the trap. A write inside these inclusive bounds is not trapped.
- R9: RAM reads are never trapped. While bit 3 of the control word is clear, RAM writes are never trapped.
- R10: A write to the window changes decoding for an access presented in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Byte address of the access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 32 | Write data; stored only for window writes |
| rsp_valid | output | 1 | Result of the previous cycle's access |
| rsp_region | output | 2 | Region code of that access |
| rsp_trap | output | 1 | Memory-exception trap for that access |
| rsp_rdata | output | 32 | Prior window word for window accesses, else 0 |

## Verification
The assertions assume that `acc_valid` and `acc_write` are never unknown after reset. They also assume that an address held with `acc_valid` low does not matter. The trap checks compare the registered response against the guard state registered together with it. This means a control-word write and a RAM write must not be issued in the same cycle. The stimulus keeps to these rules: it changes inputs only at falling edges, it drives `acc_valid` low outside accesses, and it always places a configuration write in its own cycle before the accesses that depend on it.

// File: rtl/adec_pkg.sv
package adec_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int WIN_WORDS  = 64;
    localparam int WIN_IDX_W  = $clog2(WIN_WORDS);
    localparam int RAM_WORD_W = 20;
    localparam int CODE_W     = 3;

    typedef enum logic [1:0] {
        RGN_ROM  = 2'd0,
        RGN_RAM  = 2'd1,
        RGN_PERI = 2'd2,
        RGN_BAD  = 2'd3
    } region_e;

    typedef struct packed {
        region_e                 region;
        logic [WIN_IDX_W-1:0]    win_idx;
        logic [RAM_WORD_W-1:0]   ram_word;
    } class_t;

    typedef struct packed {
        logic                    guard_on;
        logic [CODE_W-1:0]       rom_code;
        logic [CODE_W-1:0]       ram_code;
        logic [RAM_WORD_W-1:0]   seg_lo;
        logic [RAM_WORD_W-1:0]   seg_hi;
    } cfg_t;

    // Window length in bytes: 2**(min_lg + code), saturated at 2**max_lg.
    function automatic logic [ADDR_W-1:0] window_len(
        input logic [CODE_W-1:0] code,
        input int                min_lg,
        input int                max_lg
    );
        int lg;
        logic [ADDR_W-1:0] one;
        one = {{(ADDR_W-1){1'b0}}, 1'b1};
        lg  = min_lg + int'(code);
        if (lg > max_lg) lg = max_lg;
        return one << lg;
    endfunction

endpackage

// File: rtl/adec_winbank.sv
module adec_winbank
    import adec_pkg::*;
#(
    parameter int WORDS      = WIN_WORDS,
    parameter int DW         = DATA_W,
    parameter int CTRL_IDX   = 0,
    parameter int CFG_IDX    = 4,
    parameter int SEGLO_IDX  = 8,
    parameter int SEGHI_IDX  = 9,
    parameter int GUARD_BIT  = 3,
    parameter int RAMC_LSB   = 10,
    parameter int ROMC_LSB   = 18
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [$clog2(WORDS)-1:0]     wr_idx,
    input  logic [DW-1:0]                wr_data,
    input  logic [$clog2(WORDS)-1:0]     rd_idx,
    output logic [DW-1:0]                rd_data,
    output cfg_t                         cfg
);
    localparam int IW = $clog2(WORDS);

    logic [DW-1:0] bank [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[i] <= '0;
            end else if (wr_en && (wr_idx == IW'(i))) begin
                bank[i] <= wr_data;
            end
        end
    end

    assign rd_data = bank[rd_idx];

    always_comb begin
        cfg.guard_on = bank[CTRL_IDX][GUARD_BIT];
        cfg.rom_code = bank[CFG_IDX][ROMC_LSB +: CODE_W];
        cfg.ram_code = bank[CFG_IDX][RAMC_LSB +: CODE_W];
        cfg.seg_lo   = bank[SEGLO_IDX][RAM_WORD_W-1:0];
        cfg.seg_hi   = bank[SEGHI_IDX][RAM_WORD_W-1:0];
    end

    // R6
    scratch_keep_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (bank[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/adec_region.sv
module adec_region
    import adec_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ROM_BASE   = 32'h0000_0000,
    parameter logic [ADDR_W-1:0] RAM_BASE   = 32'h0200_0000,
    parameter logic [ADDR_W-1:0] PERI_BASE  = 32'h01F8_0000,
    parameter int                ROM_MIN_LG = 12,
    parameter int                ROM_MAX_LG = 19,
    parameter int                RAM_MIN_LG = 18,
    parameter int                RAM_MAX_LG = 22,
    parameter int                PERI_LG    = 8
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CODE_W-1:0]  rom_code,
    input  logic [CODE_W-1:0]  ram_code,
    output class_t             cls
);
    logic [ADDR_W-1:0] rom_len, ram_len, rom_off, ram_off;
    logic              in_rom, in_ram, in_peri;

    always_comb begin
        rom_len = window_len(rom_code, ROM_MIN_LG, ROM_MAX_LG);
        ram_len = window_len(ram_code, RAM_MIN_LG, RAM_MAX_LG);
        rom_off = addr - ROM_BASE;
        ram_off = addr - RAM_BASE;
        in_rom  = rom_off < rom_len;
        in_ram  = ram_off < ram_len;
        in_peri = addr[ADDR_W-1:PERI_LG] == PERI_BASE[ADDR_W-1:PERI_LG];

        if (in_rom)       cls.region = RGN_ROM;
        else if (in_ram)  cls.region = RGN_RAM;
        else if (in_peri) cls.region = RGN_PERI;
        else              cls.region = RGN_BAD;

        cls.win_idx  = addr[WIN_IDX_W+1:2];
        cls.ram_word = ram_off[RAM_WORD_W+1:2];
    end

endmodule

// File: rtl/adec_guard.sv
module adec_guard
    import adec_pkg::*;
(
    input  logic                   guard_on,
    input  logic                   is_write,
    input  region_e                region,
    input  logic [RAM_WORD_W-1:0]  ram_word,
    input  logic [RAM_WORD_W-1:0]  seg_lo,
    input  logic [RAM_WORD_W-1:0]  seg_hi,
    output logic                   violation
);
    logic outside;

    always_comb begin
        outside   = (ram_word < seg_lo) || (ram_word > seg_hi);
        violation = guard_on && is_write && (region == RGN_RAM) && outside;
    end

endmodule

// File: rtl/addr_guard.sv
module addr_guard
    import adec_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ROM_BASE   = 32'h0000_0000,
    parameter logic [ADDR_W-1:0] RAM_BASE   = 32'h0200_0000,
    parameter logic [ADDR_W-1:0] PERI_BASE  = 32'h01F8_0000,
    parameter int                ROM_MIN_LG = 12,
    parameter int                ROM_MAX_LG = 19,
    parameter int                RAM_MIN_LG = 18,
    parameter int                RAM_MAX_LG = 22
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                acc_valid,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic                acc_write,
    input  logic [DATA_W-1:0]   acc_wdata,
    output logic                rsp_valid,
    output logic [1:0]          rsp_region,
    output logic                rsp_trap,
    output logic [DATA_W-1:0]   rsp_rdata
);
    localparam int PERI_LG = WIN_IDX_W + 2;
    localparam logic [ADDR_W-1:0] ROM_CEIL =
        ROM_BASE + ({{(ADDR_W-1){1'b0}}, 1'b1} << ROM_MAX_LG);

    class_t              cls;
    cfg_t                cfg;
    logic [DATA_W-1:0]   win_rd;
    logic                win_wr;
    logic                violation;
    logic                wr_q, guard_q;
    region_e             region_q;

    adec_winbank #(.WORDS(WIN_WORDS), .DW(DATA_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (win_wr),
        .wr_idx  (cls.win_idx),
        .wr_data (acc_wdata),
        .rd_idx  (cls.win_idx),
        .rd_data (win_rd),
        .cfg     (cfg)
    );

    adec_region #(
        .ROM_BASE  (ROM_BASE),   .RAM_BASE  (RAM_BASE),
        .PERI_BASE (PERI_BASE),  .ROM_MIN_LG(ROM_MIN_LG),
        .ROM_MAX_LG(ROM_MAX_LG), .RAM_MIN_LG(RAM_MIN_LG),
        .RAM_MAX_LG(RAM_MAX_LG), .PERI_LG   (PERI_LG)
    ) u_region (
        .addr     (acc_addr),
        .rom_code (cfg.rom_code),
        .ram_code (cfg.ram_code),
        .cls      (cls)
    );

    adec_guard u_guard (
        .guard_on  (cfg.guard_on),
        .is_write  (acc_write),
        .region    (cls.region),
        .ram_word  (cls.ram_word),
        .seg_lo    (cfg.seg_lo),
        .seg_hi    (cfg.seg_hi),
        .violation (violation)
    );

    assign win_wr = acc_valid && acc_write && (cls.region == RGN_PERI);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            region_q  <= RGN_BAD;
            rsp_trap  <= 1'b0;
            rsp_rdata <= '0;
            wr_q      <= 1'b0;
            guard_q   <= 1'b0;
        end else begin
            rsp_valid <= acc_valid;
            wr_q      <= acc_write;
            guard_q   <= cfg.guard_on;
            if (acc_valid) begin
                region_q  <= cls.region;
                rsp_trap  <= (cls.region == RGN_BAD) || violation;
                rsp_rdata <= (cls.region == RGN_PERI) ? win_rd : '0;
            end else begin
                rsp_trap  <= 1'b0;
                rsp_rdata <= '0;
            end
        end
    end

    assign rsp_region = region_q;

    // R2
    rsp_follows_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> rsp_valid);

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (!rsp_valid && !rsp_trap));

    // R3
    rom_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && cls.region == RGN_ROM) |-> ((acc_addr - ROM_BASE) < (ROM_CEIL - ROM_BASE)));

    // R5
    bad_traps_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_region == RGN_BAD) |-> rsp_trap);

    // R6
    window_no_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_region == RGN_PERI) |-> !rsp_trap);

    // R6
    rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_region != RGN_PERI) |-> (rsp_rdata == '0));

    // R9
    read_free_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_region == RGN_RAM && !wr_q) |-> !rsp_trap);

    // R9
    guard_off_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_region == RGN_RAM && !guard_q) |-> !rsp_trap);

endmodule

// File: tb/addr_guard_bench.sv
module addr_guard_bench;
    import adec_pkg::*;

    typedef struct {
        logic [1:0]  region;
        logic        trap;
        logic [31:0] rdata;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_region;
    logic        rsp_trap;
    logic [31:0] rsp_rdata;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t sb[$];

    localparam logic [31:0] W = 32'h01F8_0000;

    always #10 clk = ~clk;

    addr_guard u_addr_guard (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_wdata(acc_wdata),
        .rsp_valid(rsp_valid), .rsp_region(rsp_region),
        .rsp_trap(rsp_trap), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] addr, input bit wr, input logic [31:0] data,
                         input logic [1:0] reg_exp, input bit trap_exp,
                         input logic [31:0] rd_exp, input string tag);
        exp_t e;
        @(negedge clk);
        acc_valid = 1'b1;
        acc_addr  = addr;
        acc_write = wr;
        acc_wdata = data;
        e.region = reg_exp; e.trap = trap_exp; e.rdata = rd_exp; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 1'b0;
        acc_write = 1'b0;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rsp_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2", "unexpected rsp_valid", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(rsp_region == e.region, e.tag, "region", 32'(rsp_region), 32'(e.region));
                    check(rsp_trap == e.trap, e.tag, "trap", 32'(rsp_trap), 32'(e.trap));
                    check(rsp_rdata == e.rdata, e.tag, "rdata", rsp_rdata, e.rdata);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs quiet while reset is held
        check(rsp_valid == 1'b0 && rsp_trap == 1'b0 && rsp_rdata == '0, "R1", "in reset",
              {rsp_valid, rsp_trap, rsp_rdata[29:0]}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1", "valid after reset", 32'(rsp_valid), 32'd0);

        // R1/R3/R4: small windows after reset
        issue(32'h0000_0FFC, 0, 0, 2'd0, 0, 0, "R1_rom4k_last");
        issue(32'h0000_1000, 0, 0, 2'd3, 1, 0, "R3_rom4k_over");
        issue(32'h0203_FFFC, 0, 0, 2'd1, 0, 0, "R4_ram256k_last");
        issue(32'h0204_0000, 1, 0, 2'd3, 1, 0, "R4_ram256k_over");
        // R5: addresses in no window
        issue(32'h1000_0000, 0, 0, 2'd3, 1, 0, "R5_far");
        issue(32'h01F8_0100, 1, 0, 2'd3, 1, 0, "R5_above_window");
        issue(32'h01F7_FFFC, 0, 0, 2'd3, 1, 0, "R5_below_window");

        // R7/R10: max codes plus junk bits, used in the next cycle
        issue(W + 32'h10, 1, 32'hA5BD_BDA5, 2'd2, 0, 32'h0, "R7_cfg_write");
        issue(32'h0007_FFFC, 0, 0, 2'd0, 0, 0, "R10_rom512k_last");
        issue(32'h0008_0000, 0, 0, 2'd3, 1, 0, "R3_rom512k_over");
        issue(32'h023F_FFFC, 1, 0, 2'd1, 0, 0, "R4_ram_cap_last");
        issue(32'h0240_0000, 0, 0, 2'd3, 1, 0, "R4_ram_cap_over");

        // R3/R4: ROM code 1 (8 KB), RAM code 2 (1 MB)
        issue(W + 32'h10, 1, 32'h0004_0800, 2'd2, 0, 32'hA5BD_BDA5, "R10_cfg_rewrite");
        issue(32'h0000_1FFC, 0, 0, 2'd0, 0, 0, "R3_rom8k_last");
        issue(32'h0000_2000, 0, 0, 2'd3, 1, 0, "R3_rom8k_over");
        issue(32'h020F_FFFC, 0, 0, 2'd1, 0, 0, "R4_ram1m_last");
        issue(32'h0210_0000, 0, 0, 2'd3, 1, 0, "R4_ram1m_over");

        // R6: scratch words
        issue(W + 32'hF0, 1, 32'hDEAD_BEEF, 2'd2, 0, 32'h0, "R6_scratch_wr");
        issue(W + 32'hF0, 0, 0, 2'd2, 0, 32'hDEAD_BEEF, "R6_scratch_rd");
        issue(W + 32'h44, 1, 32'h1234_5678, 2'd2, 0, 32'h0, "R6_scratch_wr2");
        issue(W + 32'h46, 0, 0, 2'd2, 0, 32'h1234_5678, "R6_byte_offset_rd");
        issue(W + 32'h10, 0, 0, 2'd2, 0, 32'h0004_0800, "R6_cfg_readback");
        idle();

        // R8/R9: guard setup, RAM code 4 (4 MB)
        issue(W + 32'h10, 1, 32'h0000_1000, 2'd2, 0, 32'h0004_0800, "R8_cfg");
        issue(W + 32'h20, 1, 32'h0000_0100, 2'd2, 0, 32'h0, "R8_lo");
        issue(W + 32'h24, 1, 32'h0000_01FF, 2'd2, 0, 32'h0, "R8_hi");
        issue(32'h0200_0140, 1, 0, 2'd1, 0, 0, "R9_guard_off_write");
        issue(W + 32'h00, 1, 32'h0000_0008, 2'd2, 0, 32'h0, "R8_enable");
        issue(32'h0200_0140, 1, 0, 2'd1, 1, 0, "R8_below_lo");
        issue(32'h0200_0400, 1, 0, 2'd1, 0, 0, "R8_at_lo");
        issue(32'h0200_07FC, 1, 0, 2'd1, 0, 0, "R8_at_hi");
        issue(32'h0200_0800, 1, 0, 2'd1, 1, 0, "R8_above_hi");
        issue(32'h0200_0140, 0, 0, 2'd1, 0, 0, "R9_read_outside");
        issue(W + 32'h00, 1, 32'h0000_00F7, 2'd2, 0, 32'h8, "R9_disable");
        issue(32'h0200_0140, 1, 0, 2'd1, 0, 0, "R9_guard_cleared");
        idle();

        repeat (3) @(negedge clk);
        // R2: nothing left outstanding
        check(sb.size() == 0, "R2", "outstanding", 32'(sb.size()), 32'd0);
        check(rsp_valid == 1'b0, "R2", "idle valid", 32'(rsp_valid), 32'd0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule